// File: doc/BRIEF.md
# SD Card Receive Data Path

This block takes read data arriving from a card on one or four data lines and turns it into 32-bit words. Each block on the wire opens with a low start bit on every active line. The payload follows, most significant bit first. Each line then carries its own 16-bit CRC, and a high end bit closes the block. The engine counts down the bytes still owed and checks every block's CRC. It packs bytes into words and places them in a 16-word FIFO, which the host empties one word at a time.

Software drives the block through four write addresses. Address 0 is control, address 1 is the total byte count, address 2 is the wait limit in bit times and address 3 is the flag-clear register. A transfer starts from the control enable bit or from a trigger pulse sent by the command side. A 32-bit status word reports sticky event flags and live FIFO and activity state. One data bit per line is sampled on each clock in which `bit_stb_i` is high.

Top module: `sdrx_datapath`

## Requirements
- R1: After reset the status word is 0x0008_0000 (only FIFO-empty, bit 19, set), `remaining_o` is 0 and bit 12 (active) is low.
- R2: A write to address 0 with bit 0 (enable) and bit 1 (card-to-host) both set starts a transfer. Bits [7:4] of the same write set the block size to 2^n bytes. If bit 1 is clear, the enable is ignored: active stays low and `remaining_o` keeps its value.
- R3: A one-cycle pulse on `cmd_trig_i` starts a transfer while the stored direction bit is 1 and the engine is idle.
- R4: In 1-line mode only line 0 is used. The payload is sent MSB first and checked with a CRC16 using polynomial 0x1021 and zero initial value.
- R5: In 4-line mode (`wide_i`=1 at start) each byte arrives as two nibbles, high nibble first, with line 3 carrying the nibble MSB. Each line has its own CRC16, and all four must match.
- R6: Each block carries 2^n bytes, or the bytes still remaining if fewer. Every block with correct CRCs sets block-end (bit 10).
- R7: At start, `remaining_o` is loaded from address 1 and then drops by one for each received byte. When it reaches zero after a good block, data-end (bit 8) is set and active (bit 12) falls.
- R8: Bytes fill FIFO words little-endian, with the first byte in bits [7:0]. A final partial word is padded with zero bytes.
- R9: A CRC mismatch on any active line sets bit 1, does not set block-end or data-end, and returns the engine to idle.
- R10: While the engine waits for a start bit, it counts bit times. If a strobe arrives with the count already at the address-2 value, bit 3 is set and the engine goes idle. With a limit of 5, the sixth idle strobe fires it and the fifth does not.
- R11: The FIFO holds 16 words. Bit 15 is set while at least 8 words wait and bit 19 while none do. A word arriving at a full FIFO is dropped and sets overrun (bit 5).
- R12: Writing address 3 clears each of the sticky flags (bits 1, 3, 5, 8, 10) whose position holds a 1 and leaves the others unchanged.
- R13: A write to address 0 with bit 13 set empties the FIFO and returns the engine to idle, even in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 length, 2 wait limit, 3 clear) |
| reg_wdata | input | 32 | Register write data |
| wide_i | input | 1 | 1 selects 4-line mode, sampled at transfer start |
| cmd_trig_i | input | 1 | Start pulse from the command side |
| bit_stb_i | input | 1 | Qualifies one card bit time |
| dat_i | input | 4 | Card data lines |
| fifo_pop_i | input | 1 | Removes the head FIFO word |
| fifo_word_o | output | 32 | Head FIFO word |
| remaining_o | output | 24 | Bytes still to be received |
| status_o | output | 32 | Status flags |

## Verification
A wrong internal state shows up at the ports as a wrong data word, a missing flag or a stuck active bit. A nibble or bit ordering error corrupts the word at the FIFO head within two clocks of the byte's last strobe. A bad CRC register or phase counter makes block-end or CRC-fail wrong on the end-bit strobe. A bad remaining counter shows at `remaining_o` on every byte and leaves data-end set one block early or late. A FIFO occupancy error shows as half-full or empty toggling at the wrong pop, which is why the bench checks the count-8 boundary.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
   typedef enum logic [2:0] {RX_IDLE, RX_WAIT, RX_DATA, RX_CRC, RX_END} rx_state_e;

   localparam int ST_CRCFAIL = 1;
   localparam int ST_TMO     = 3;
   localparam int ST_OVR     = 5;
   localparam int ST_DEND    = 8;
   localparam int ST_BEND    = 10;
   localparam int ST_ACT     = 12;
   localparam int ST_HALF    = 15;
   localparam int ST_EMPTY   = 19;

   localparam int CTL_EN   = 0;
   localparam int CTL_DIR  = 1;
   localparam int CTL_EXP  = 4;
   localparam int CTL_FRST = 13;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_LEN  = 2'd1;
   localparam logic [1:0] A_TMO  = 2'd2;
   localparam logic [1:0] A_CLR  = 2'd3;

   localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/sdrx_crc16.sv
module sdrx_crc16 #(
   parameter int          W    = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] rem
);
   if (W < 2) begin : g_chk
      $error("sdrx_crc16: W must be at least 2");
   end

   logic fb;
   assign fb = rem[W-1] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rem <= '0;
      else if (clr) rem <= '0;
      else if (en)  rem <= {rem[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
   end
endmodule

// File: rtl/sdrx_packer.sv
module sdrx_packer #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          byte_vld,
   input  logic [7:0]    byte_dat,
   input  logic          byte_last,
   output logic          word_vld,
   output logic [DW-1:0] word_dat
);
   localparam int NB = DW / 8;
   localparam int IW = (NB > 1) ? $clog2(NB) : 1;

   if ((DW % 8) != 0 || NB < 2) begin : g_chk
      $error("sdrx_packer: DW must be a multiple of 8 and at least 16");
   end

   logic [DW-1:0] acc, merged;
   logic [IW-1:0] idx;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign merged[b*8 +: 8] = (idx == IW'(b)) ? byte_dat : acc[b*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         idx      <= '0;
         word_vld <= 1'b0;
         word_dat <= '0;
      end else begin
         word_vld <= 1'b0;
         if (flush) begin
            acc <= '0;
            idx <= '0;
         end else if (byte_vld) begin
            if (idx == IW'(NB-1) || byte_last) begin
               word_vld <= 1'b1;
               word_dat <= merged;
               acc      <= '0;
               idx      <= '0;
            end else begin
               acc <= merged;
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sdrx_fifo.sv
module sdrx_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [AW:0]   count,
   output logic          full,
   output logic          empty,
   output logic          ovf
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_chk
      $error("sdrx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign ovf     = push && full && !flush;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end
endmodule

// File: rtl/sdrx_datapath.sv
module sdrx_datapath
   import sdrx_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   parameter int LEN_W = 24,
   parameter int TMO_W = 32,
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   input  logic             wide_i,
   input  logic             cmd_trig_i,
   input  logic             bit_stb_i,
   input  logic [LANES-1:0] dat_i,
   input  logic             fifo_pop_i,
   output logic [DW-1:0]    fifo_word_o,
   output logic [LEN_W-1:0] remaining_o,
   output logic [31:0]      status_o
);
   localparam int AW   = $clog2(DEPTH);
   localparam int HALF = DEPTH / 2;

   if (LANES != 4) begin : g_chk_lanes
      $error("sdrx_datapath: LANES must be 4");
   end
   if (LEN_W < 16 || LEN_W > 32 || TMO_W > 32) begin : g_chk_w
      $error("sdrx_datapath: LEN_W must be 16..32 and TMO_W at most 32");
   end

   rx_state_e        state;
   logic             dir_q, wide_q;
   logic [3:0]       exp_q;
   logic [LEN_W-1:0] len_q, rem_q, blk_left;
   logic [TMO_W-1:0] tmo_q, tmo_cnt;
   logic [2:0]       bitcnt;
   logic [3:0]       crc_cnt;
   logic [7:0]       sh, sh_next;
   logic             byte_vld, byte_last;
   logic [7:0]       byte_dat;
   logic             f_crc, f_tmo, f_ovr, f_dend, f_bend;

   logic ctrl_wr, frst, start, start_bit, crc_ok, crc_clr, crc_en;
   logic [LANES-1:0] lane_mask;
   logic [LEN_W-1:0] blk_size, blk_first;
   logic [2:0]       last_step;

   assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
   assign frst      = ctrl_wr && reg_wdata[CTL_FRST];
   assign start     = !frst && (state == RX_IDLE) &&
                      ((ctrl_wr && reg_wdata[CTL_EN] && reg_wdata[CTL_DIR]) ||
                       (!ctrl_wr && cmd_trig_i && dir_q));
   assign lane_mask = wide_q ? {LANES{1'b1}} : LANES'(1);
   assign start_bit = ((dat_i & lane_mask) == '0);
   assign blk_size  = LEN_W'(1) << exp_q;
   assign blk_first = (rem_q < blk_size) ? rem_q : blk_size;
   assign last_step = wide_q ? 3'd1 : 3'd7;
   assign sh_next   = wide_q ? {sh[3:0], dat_i[3:0]} : {sh[6:0], dat_i[0]};

   // per-lane CRC checkers
   logic [15:0]      crc_rem [LANES];
   logic [LANES-1:0] lane_zero;
   assign crc_clr = (state == RX_WAIT);
   assign crc_en  = bit_stb_i && ((state == RX_DATA) || (state == RX_CRC));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sdrx_crc16 #(.W(16), .POLY(CRC_POLY)) u_crc (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (crc_clr),
         .en   (crc_en),
         .din  (dat_i[l]),
         .rem  (crc_rem[l])
      );
      assign lane_zero[l] = (crc_rem[l] == 16'h0) || !lane_mask[l];
   end
   assign crc_ok = &lane_zero;

   // word assembly and FIFO
   logic          word_vld;
   logic [DW-1:0] word_dat;
   logic [AW:0]   fifo_cnt;
   logic          fifo_full, fifo_empty, fifo_ovf;

   sdrx_packer #(.DW(DW)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (frst),
      .byte_vld (byte_vld),
      .byte_dat (byte_dat),
      .byte_last(byte_last),
      .word_vld (word_vld),
      .word_dat (word_dat)
   );

   sdrx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(frst),
      .push (word_vld),
      .wdata(word_dat),
      .pop  (fifo_pop_i),
      .rdata(fifo_word_o),
      .count(fifo_cnt),
      .full (fifo_full),
      .empty(fifo_empty),
      .ovf  (fifo_ovf)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
         exp_q <= '0;
         len_q <= '0;
         tmo_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_CTRL: begin
               dir_q <= reg_wdata[CTL_DIR];
               exp_q <= reg_wdata[CTL_EXP +: 4];
            end
            A_LEN:   len_q <= reg_wdata[LEN_W-1:0];
            A_TMO:   tmo_q <= reg_wdata[TMO_W-1:0];
            default: ;
         endcase
      end
   end

   // receive engine and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         wide_q   <= 1'b0;
         rem_q    <= '0;
         blk_left <= '0;
         tmo_cnt  <= '0;
         bitcnt   <= '0;
         crc_cnt  <= '0;
         sh       <= '0;
         byte_vld <= 1'b0;
         byte_dat <= '0;
         byte_last <= 1'b0;
         {f_crc, f_tmo, f_ovr, f_dend, f_bend} <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (reg_wr && reg_addr == A_CLR) begin
            if (reg_wdata[ST_CRCFAIL]) f_crc  <= 1'b0;
            if (reg_wdata[ST_TMO])     f_tmo  <= 1'b0;
            if (reg_wdata[ST_OVR])     f_ovr  <= 1'b0;
            if (reg_wdata[ST_DEND])    f_dend <= 1'b0;
            if (reg_wdata[ST_BEND])    f_bend <= 1'b0;
         end
         if (fifo_ovf) f_ovr <= 1'b1;

         if (frst) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: if (start) begin
                  state   <= RX_WAIT;
                  rem_q   <= len_q;
                  tmo_cnt <= tmo_q;
                  wide_q  <= wide_i;
               end
               RX_WAIT: if (bit_stb_i) begin
                  if (start_bit) begin
                     state    <= RX_DATA;
                     blk_left <= blk_first;
                     bitcnt   <= '0;
                  end else if (tmo_cnt == '0) begin
                     f_tmo <= 1'b1;
                     state <= RX_IDLE;
                  end else begin
                     tmo_cnt <= tmo_cnt - 1'b1;
                  end
               end
               RX_DATA: if (bit_stb_i) begin
                  sh <= sh_next;
                  if (bitcnt == last_step) begin
                     bitcnt    <= '0;
                     byte_vld  <= 1'b1;
                     byte_dat  <= sh_next;
                     byte_last <= (rem_q == LEN_W'(1));
                     rem_q     <= rem_q - 1'b1;
                     blk_left  <= blk_left - 1'b1;
                     if (blk_left == LEN_W'(1)) begin
                        state   <= RX_CRC;
                        crc_cnt <= '0;
                     end
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
               RX_CRC: if (bit_stb_i) begin
                  crc_cnt <= crc_cnt + 1'b1;
                  if (crc_cnt == 4'd15) state <= RX_END;
               end
               RX_END: if (bit_stb_i) begin
                  if (crc_ok) begin
                     f_bend <= 1'b1;
                     if (rem_q == '0) begin
                        f_dend <= 1'b1;
                        state  <= RX_IDLE;
                     end else begin
                        state   <= RX_WAIT;
                        tmo_cnt <= tmo_q;
                     end
                  end else begin
                     f_crc <= 1'b1;
                     state <= RX_IDLE;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      status_o             = '0;
      status_o[ST_CRCFAIL] = f_crc;
      status_o[ST_TMO]     = f_tmo;
      status_o[ST_OVR]     = f_ovr;
      status_o[ST_DEND]    = f_dend;
      status_o[ST_BEND]    = f_bend;
      status_o[ST_ACT]     = (state != RX_IDLE);
      status_o[ST_HALF]    = (fifo_cnt >= (AW+1)'(HALF));
      status_o[ST_EMPTY]   = fifo_empty;
   end

   assign remaining_o = rem_q;

   logic unused_full;
   assign unused_full = fifo_full;
endmodule

// File: rtl/sdrx_datapath_chk.sv
module sdrx_datapath_chk #(
   parameter int LEN_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic             wd_frst,
   input logic [LEN_W-1:0] remaining,
   input logic             s_crc,
   input logic             s_tmo,
   input logic             s_dend,
   input logic             s_act,
   input logic             s_half,
   input logic             s_empty
);
   p_half_empty_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_half && s_empty));

   p_fifo_reset_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && wd_frst) |=> (s_empty && !s_act));

   p_dend_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_dend) |-> (remaining == '0 && !s_act));

   p_rem_never_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_act && $past(s_act)) |-> (remaining <= $past(remaining)));

   p_crcfail_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_crc) |-> !s_act);

   p_timeout_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_tmo) |-> !s_act);
endmodule

bind sdrx_datapath sdrx_datapath_chk #(.LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .wd_frst  (reg_wdata[13]),
   .remaining(remaining_o),
   .s_crc    (status_o[1]),
   .s_tmo    (status_o[3]),
   .s_dend   (status_o[8]),
   .s_act    (status_o[12]),
   .s_half   (status_o[15]),
   .s_empty  (status_o[19])
);

// File: tb/sdrx_datapath_tb.sv
module sdrx_datapath_tb_top;
   localparam int CLK_P = 10;
   localparam int NV = 4;
   // stimulus and expected results: mode, size exponent, length, seed, words
   localparam int V_WIDE [NV] = '{0, 1, 1, 0};
   localparam int V_EXP  [NV] = '{3, 3, 2, 4};
   localparam int V_LEN  [NV] = '{8, 16, 6, 20};
   localparam int V_SEED [NV] = '{5, 9, 3, 64};
   localparam int V_WRDS [NV] = '{2, 4, 2, 5};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        wide = 1'b0, trig = 1'b0, stb = 1'b0, pop = 1'b0;
   logic [3:0]  dat = 4'hF;
   logic [31:0] word;
   logic [23:0] rem;
   logic [31:0] st;

   int n_chk = 0, n_err = 0;
   logic [7:0] tx [0:255];

   always #(CLK_P/2) clk = ~clk;

   sdrx_datapath dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .wide_i(wide), .cmd_trig_i(trig),
      .bit_stb_i(stb), .dat_i(dat), .fifo_pop_i(pop),
      .fifo_word_o(word), .remaining_o(rem), .status_o(st)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic strobe(input logic [3:0] d);
      @(negedge clk); dat = d; stb = 1'b1;
      @(negedge clk); stb = 1'b0;
   endtask

   task automatic do_pop();
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
   endtask

   function automatic void fill(input int seed);
      for (int k = 0; k < 256; k++) tx[k] = 8'(seed + k * 37);
   endfunction

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic d);
      logic fb;
      fb = c[15] ^ d;
      return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
   endfunction

   function automatic logic lane_bit(input bit w, input int first, input int s, input int l);
      logic [7:0] b;
      if (w) begin
         b = tx[first + s/2];
         return (s % 2 == 0) ? b[4+l] : b[l];
      end
      b = tx[first + s/8];
      return b[7 - (s % 8)];
   endfunction

   function automatic logic [31:0] exp_word(input int len, input int w);
      logic [31:0] v = '0;
      for (int b = 0; b < 4; b++)
         if (4*w + b < len) v[8*b +: 8] = tx[4*w + b];
      return v;
   endfunction

   task automatic send_block(input bit w, input int first, input int n, input int bad);
      logic [15:0] c [4];
      logic [3:0]  d;
      int steps;
      for (int l = 0; l < 4; l++) c[l] = '0;
      steps = w ? 2*n : 8*n;
      for (int s = 0; s < steps; s++)
         for (int l = 0; l < 4; l++)
            if (w || l == 0) c[l] = crc_step(c[l], lane_bit(w, first, s, l));
      strobe(w ? 4'h0 : 4'hE);
      for (int s = 0; s < steps; s++) begin
         d = 4'hF;
         for (int l = 0; l < 4; l++) if (w || l == 0) d[l] = lane_bit(w, first, s, l);
         strobe(d);
      end
      for (int i = 0; i < 16; i++) begin
         d = 4'hF;
         for (int l = 0; l < 4; l++)
            if (w || l == 0) begin
               d[l] = c[l][15-i];
               if (l == bad && i == 0) d[l] = ~d[l];
            end
         strobe(d);
      end
      strobe(4'hF);
      strobe(4'hF);
   endtask

   task automatic send_all(input bit w, input int ex, input int len);
      int first = 0;
      while (first < len) begin
         int n = ((1 << ex) < len - first) ? (1 << ex) : len - first;
         send_block(w, first, n, -1);
         first += n;
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status", st, 32'h0008_0000);
      chk("R1 remaining", rem, 0);

      // enable with direction clear is ignored
      wr(2'd1, 32'd8);
      wr(2'd0, 32'h31);
      chk("R2 dir0 active", st[12], 0);
      chk("R2 dir0 remaining", rem, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         fill(V_SEED[v]);
         wide = V_WIDE[v][0];
         wr(2'd3, 32'hFFFF_FFFF);
         wr(2'd1, V_LEN[v]);
         wr(2'd2, 32'd1000);
         wr(2'd0, 32'h3 | (V_EXP[v] << 4));
         chk("R2 started active", st[12], 1);
         chk("R7 remaining loaded", rem, V_LEN[v]);
         send_all(wide, V_EXP[v], V_LEN[v]);
         chk("R7 data-end", st[8], 1);
         chk("R6 block-end", st[10], 1);
         chk("R7 idle after end", st[12], 0);
         chk("R7 remaining zero", rem, 0);
         chk(wide ? "R5 crc clean" : "R4 crc clean", st[1], 0);
         chk("R11 not empty", st[19], 0);
         for (int w = 0; w < V_WRDS[v]; w++) begin
            chk(wide ? "R5 R8 word" : "R4 R8 word", word, exp_word(V_LEN[v], w));
            do_pop();
         end
         chk("R11 empty after drain", st[19], 1);
      end

      // trigger start
      fill(17);
      wide = 1'b0;
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd1, 32'd8);
      wr(2'd0, 32'h32);
      chk("R3 no start without trigger", st[12], 0);
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      chk("R3 trigger active", st[12], 1);
      chk("R3 remaining", rem, 8);
      send_block(1'b0, 0, 8, -1);
      chk("R3 data-end", st[8], 1);
      chk("R3 word0", word, exp_word(8, 0));
      do_pop();
      do_pop();

      // CRC error on line 2, 4-line mode
      fill(99);
      wide = 1'b1;
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd1, 32'd16);
      wr(2'd0, 32'h33);
      send_block(1'b1, 0, 8, 2);
      chk("R9 crc flag", st[1], 1);
      chk("R9 no block-end", st[10], 0);
      chk("R9 no data-end", st[8], 0);
      chk("R9 idle", st[12], 0);
      wr(2'd0, 32'h2000);
      chk("R13 flushed", st[19], 1);
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R12 all cleared", st, 32'h0008_0000);

      // wait-limit boundary
      wide = 1'b0;
      wr(2'd1, 32'd8);
      wr(2'd2, 32'd5);
      wr(2'd0, 32'h33);
      repeat (5) strobe(4'hF);
      chk("R10 not yet", st[3], 0);
      chk("R10 still active", st[12], 1);
      strobe(4'hF);
      chk("R10 timeout", st[3], 1);
      chk("R10 idle", st[12], 0);
      wr(2'd3, 32'h8);

      // overrun and half-full
      fill(200);
      wr(2'd1, 32'd72);
      wr(2'd2, 32'd1000);
      wr(2'd0, 32'h63);
      send_all(1'b0, 6, 72);
      chk("R11 overrun", st[5], 1);
      chk("R11 half full", st[15], 1);
      chk("R7 data-end long", st[8], 1);
      chk("R11 head word", word, exp_word(72, 0));
      repeat (8) do_pop();
      chk("R11 half at 8", st[15], 1);
      chk("R11 word 8", word, exp_word(72, 8));
      do_pop();
      chk("R11 half below 8", st[15], 0);
      repeat (7) do_pop();
      chk("R11 empty", st[19], 1);
      wr(2'd3, 32'h20);
      chk("R12 overrun cleared", st[5], 0);
      chk("R12 data-end kept", st[8], 1);

      // FIFO reset mid-block
      fill(1);
      wr(2'd1, 32'd16);
      wr(2'd0, 32'h43);
      strobe(4'hE);
      for (int s = 0; s < 40; s++) strobe({3'b111, lane_bit(1'b0, 0, s, 0)});
      repeat (3) @(negedge clk);
      chk("R13 word present", st[19], 0);
      wr(2'd0, 32'h2000);
      chk("R13 idle", st[12], 0);
      chk("R13 empty", st[19], 1);

      summary();
      $finish;
   end
endmodule